// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block is the slave-side command logic that a serial flash uses to manage its status register. It oversamples SPI mode-0 traffic (chip select, serial clock and serial data in) with the chip's own clock. It decodes four one-byte instructions and holds the status bits. It also models the self-timed internal write cycle that follows a status update. The memory array itself is not part of this block.

A host first sends write-enable. It then sends write-status with one data byte and raises chip select exactly after that byte. A busy period follows, and the host polls the busy flag with read-status until it clears. A write-protect pin can lock the status register once its lock bit is set. An active-low device reset pin aborts serial commands. A write cycle that is already running is allowed to finish first.

Top module: `spiStatusCtrl`

## Requirements
- R1: After system reset the status byte reads 0x00 and the output enable `misoOe` is low.
- R2: Opcode 0x06 sets the enable latch (status bit 1) and opcode 0x04 clears it. Each takes effect only when chip select rises after exactly 8 clocked bits.
- R3: Opcode 0x05 drives the status byte on `miso`, most significant bit first, changing after falling SCK edges. The byte is re-sampled and repeated for every further 8 clocks while chip select stays low. `misoOe` is high only while this instruction is active.
- R4: Opcode 0x01 (write-status) has no effect when the enable latch is 0.
- R5: A write-status commits only if chip select rises after exactly 16 bits (opcode plus one data byte). With any other count it is discarded: no busy period starts, and the enable latch keeps its value.
- R6: Only bit 7 (lock bit) and bits 4:2 (protect field) take the written data. Bits 6 and 5 always read 0, and data bits 1 and 0 are ignored.
- R7: An accepted write-status starts a busy period of `WRITE_CYCLES` clocks. During it, status bit 0 reads 1, the enable latch still reads 1, and bits 7 and 4:2 still show their old values.
- R8: When the busy period ends, bit 0 reads 0, the enable latch is cleared, and the new values of bits 7 and 4:2 become visible.
- R9: When the lock bit is 1 and `wpN` is low, write-status is rejected. No busy period starts, the bits are unchanged, and the enable latch stays set.
- R10: An opcode other than 0x06, 0x04, 0x05 or 0x01 is ignored until chip select rises. It changes no status bit and leaves `misoOe` low.
- R11: While `devRstN` is low, serial commands are ignored, `misoOe` stays low and the enable latch is cleared. A busy period that is already running still completes and commits its data.
- R12: While the busy period runs, write-enable, write-disable and write-status instructions are ignored. Read-status still works.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rstN | input | 1 | Active-low system reset |
| csN | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, mode 0 |
| mosi | input | 1 | Serial data into the device |
| wpN | input | 1 | Write-protect pin, active low |
| devRstN | input | 1 | Active-low device reset pin |
| miso | output | 1 | Serial data out of the device |
| misoOe | output | 1 | Output enable for `miso`; low means high impedance |

## Verification
The bench builds the block with `WRITE_CYCLES` = 400 and two synchronizer stages, and drives SCK with a half period of six clocks. At that length the busy period outlasts a whole read-status transfer, so polls land inside it. The busy period still ends partway through a six-byte repeated read, which shows the busy flag falling within one chip-select frame. A short cycle also keeps a sweep of 64 data bytes through write, poll and read-back affordable, and expected values come from masking each byte arithmetically.

// File: rtl/spiStatusPkg.sv
package spiStatusPkg;

  localparam logic [7:0] OP_SET_LATCH = 8'h06;
  localparam logic [7:0] OP_CLR_LATCH = 8'h04;
  localparam logic [7:0] OP_READ_STAT = 8'h05;
  localparam logic [7:0] OP_WRITE_STAT = 8'h01;

  // bits that a status write may change: lock bit 7, protect field 4:2
  localparam logic [7:0] WRITABLE_MASK = 8'h9C;
  localparam int LOCK_BIT = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPCODE,
    ST_WRDATA,
    ST_READ,
    ST_SIMPLE,
    ST_SKIP
  } cmdState_t;

  typedef struct packed {
    logic       setWel;
    logic       clrWel;
    logic       wrReq;
    logic [7:0] wrData;
    logic       outLoad;
    logic       outShift;
    logic       devReset;
  } ctrlStrobe_t;

endpackage

// File: rtl/syncChain.sv
module syncChain #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RESET_VAL;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/statusCtrlFsm.sv
module statusCtrlFsm
  import spiStatusPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csSync,
  input  logic        sckSync,
  input  logic        mosiSync,
  input  logic        devRunSync,
  output ctrlStrobe_t strobe,
  output logic        readActive
);

  cmdState_t  state;
  logic       sckPrev;
  logic [2:0] bitCnt;
  logic [1:0] byteCnt;
  logic [7:0] shiftIn;
  logic       opWren;

  logic       sckRise, sckFall, selActive, cmdDone;
  logic [7:0] nextByte;

  assign sckRise   = sckSync & ~sckPrev;
  assign sckFall   = ~sckSync & sckPrev;
  assign selActive = ~csSync & devRunSync;
  assign cmdDone   = (state != ST_IDLE) && csSync && devRunSync;
  assign nextByte  = {shiftIn[6:0], mosiSync};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      sckPrev <= 1'b0;
      bitCnt  <= '0;
      byteCnt <= '0;
      shiftIn <= '0;
      opWren  <= 1'b0;
    end else begin
      sckPrev <= sckSync;
      if (!selActive) begin
        state <= ST_IDLE;
      end else if (state == ST_IDLE) begin
        state   <= ST_OPCODE;
        bitCnt  <= '0;
        byteCnt <= '0;
      end else if (sckRise) begin
        shiftIn <= nextByte;
        bitCnt  <= bitCnt + 3'd1;
        if (bitCnt == 3'd7) begin
          if (byteCnt != 2'd3) byteCnt <= byteCnt + 2'd1;
          if (state == ST_OPCODE) begin
            case (nextByte)
              OP_SET_LATCH: begin state <= ST_SIMPLE; opWren <= 1'b1; end
              OP_CLR_LATCH: begin state <= ST_SIMPLE; opWren <= 1'b0; end
              OP_READ_STAT: state <= ST_READ;
              OP_WRITE_STAT: state <= ST_WRDATA;
              default:      state <= ST_SKIP;
            endcase
          end
        end
      end
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.setWel   = cmdDone && state == ST_SIMPLE && opWren &&
                      byteCnt == 2'd1 && bitCnt == 3'd0;
    strobe.clrWel   = cmdDone && state == ST_SIMPLE && !opWren &&
                      byteCnt == 2'd1 && bitCnt == 3'd0;
    strobe.wrReq    = cmdDone && state == ST_WRDATA &&
                      byteCnt == 2'd2 && bitCnt == 3'd0;
    strobe.wrData   = shiftIn;
    strobe.outLoad  = state == ST_READ && selActive && sckFall && bitCnt == 3'd0;
    strobe.outShift = state == ST_READ && selActive && sckFall && bitCnt != 3'd0;
    strobe.devReset = ~devRunSync;
  end

  assign readActive = (state == ST_READ) && selActive;

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.setWel, strobe.clrWel, strobe.wrReq, strobe.outLoad, strobe.outShift}));

  // R11
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !devRunSync |=> state == ST_IDLE);

  // R5
  write_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrReq |-> $past(state) == ST_WRDATA && $past(byteCnt) == 2'd2);

endmodule

// File: rtl/statusDatapath.sv
module statusDatapath
  import spiStatusPkg::*;
#(
  parameter int WRITE_CYCLES = 1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic        wpSync,
  output logic        misoBit
);

  localparam int CNT_W = (WRITE_CYCLES > 2) ? $clog2(WRITE_CYCLES) : 1;

  logic [7:0]       nvBits;
  logic [7:0]       pendBits;
  logic             wel, wip;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       outReg;
  logic [7:0]       statusByte;
  logic             writeAllowed;

  assign statusByte   = nvBits | {6'b0, wel, wip};
  assign writeAllowed = wel && !wip && !(nvBits[LOCK_BIT] && !wpSync);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nvBits   <= '0;
      pendBits <= '0;
      wel      <= 1'b0;
      wip      <= 1'b0;
      cnt      <= '0;
    end else if (wip) begin
      if (cnt == '0) begin
        wip    <= 1'b0;
        wel    <= 1'b0;
        nvBits <= pendBits;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (strobe.devReset) begin
      wel <= 1'b0;
    end else if (strobe.wrReq && writeAllowed) begin
      wip      <= 1'b1;
      cnt      <= CNT_W'(WRITE_CYCLES - 1);
      pendBits <= strobe.wrData & WRITABLE_MASK;
    end else if (strobe.setWel) begin
      wel <= 1'b1;
    end else if (strobe.clrWel) begin
      wel <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outReg <= '0;
    else if (strobe.outLoad) outReg <= statusByte;
    else if (strobe.outShift) outReg <= {outReg[6:0], 1'b0};
  end

  assign misoBit = outReg[7];

  // R8
  wel_clear_on_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wip) |-> !wel);

  // R7
  wip_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wip) |-> $past(strobe.wrReq) && $past(wel));

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wip && cnt != '0) |=> wip);

  // R6
  nv_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    $stable(nvBits) || $fell(wip));

  // R9
  lock_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrReq && !wip && nvBits[LOCK_BIT] && !wpSync) |=> !wip);

endmodule

// File: rtl/spiStatusCtrl.sv
module spiStatusCtrl
  import spiStatusPkg::*;
#(
  parameter int WRITE_CYCLES = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sck,
  input  logic mosi,
  input  logic wpN,
  input  logic devRstN,
  output logic miso,
  output logic misoOe
);

  logic [4:0]  pinSync;
  ctrlStrobe_t strobe;
  logic        readActive;

  // order: cs, sck, mosi, wp, device-run; idle values cs=1, wp=1, run=1
  syncChain #(
    .WIDTH(5),
    .STAGES(SYNC_STAGES),
    .RESET_VAL(5'b10011)
  ) i_pinSync (
    .clk (clk),
    .rstN(rstN),
    .din ({csN, sck, mosi, wpN, devRstN}),
    .dout(pinSync)
  );

  statusCtrlFsm i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .csSync    (pinSync[4]),
    .sckSync   (pinSync[3]),
    .mosiSync  (pinSync[2]),
    .devRunSync(pinSync[0]),
    .strobe    (strobe),
    .readActive(readActive)
  );

  statusDatapath #(
    .WRITE_CYCLES(WRITE_CYCLES)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wpSync (pinSync[1]),
    .misoBit(miso)
  );

  assign misoOe = readActive;

endmodule

// File: tb/test_spiStatusCtrl.sv
module test_spiStatusCtrl;

  localparam int WCYC = 400;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rstN, csN, sck, mosi, wpN, devRstN;
  logic miso, misoOe;
  int   errors = 0;
  int   checks = 0;
  bit   finished = 1'b0;

  always #2 clk = ~clk;

  spiStatusCtrl #(.WRITE_CYCLES(WCYC), .SYNC_STAGES(2)) i_spiStatusCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .mosi(mosi),
    .wpN(wpN), .devRstN(devRstN), .miso(miso), .misoOe(misoOe)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic csAssert();
    csN = 1'b0;
    tick(HALF);
  endtask

  task automatic csRelease();
    tick(HALF);
    csN = 1'b1;
    tick(2 * HALF);
  endtask

  task automatic xferBits(input logic [7:0] tx, input int n,
                          output logic [7:0] rx, output bit oeAll);
    rx = '0;
    oeAll = 1'b1;
    for (int i = n - 1; i >= 0; i--) begin
      mosi = tx[i];
      tick(HALF);
      rx[i] = miso;
      if (!misoOe) oeAll = 1'b0;
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic sendByte(input logic [7:0] tx);
    logic [7:0] rx;
    bit oe;
    xferBits(tx, 8, rx, oe);
  endtask

  task automatic cmdByte(input logic [7:0] op);
    csAssert();
    sendByte(op);
    csRelease();
  endtask

  task automatic writeStatus(input logic [7:0] d);
    csAssert();
    sendByte(8'h01);
    sendByte(d);
    csRelease();
  endtask

  task automatic readStatus(output logic [7:0] st, output bit oe);
    csAssert();
    sendByte(8'h05);
    xferBits(8'h00, 8, st, oe);
    csRelease();
  endtask

  task automatic waitIdle(output logic [7:0] st);
    bit oe;
    st = 8'h01;
    for (int k = 0; k < 12 && st[0]; k++) readStatus(st, oe);
  endtask

  initial begin
    logic [7:0] st, prev, d, rx;
    bit oe;
    rstN = 1'b0; csN = 1'b1; sck = 1'b0; mosi = 1'b0; wpN = 1'b1; devRstN = 1'b1;
    tick(5);
    // R1 output enable low in reset
    check(misoOe == 1'b0, "R1 oe in reset", misoOe, 0);
    rstN = 1'b1;
    tick(5);
    readStatus(st, oe);
    check(st == 8'h00, "R1 status after reset", st, 8'h00);
    check(oe, "R3 oe during read", oe, 1);
    tick(1);
    check(misoOe == 1'b0, "R3 oe after read", misoOe, 0);

    // R10 unknown opcode
    cmdByte(8'h06);
    csAssert();
    sendByte(8'hAB);
    xferBits(8'h00, 8, rx, oe);
    check(misoOe == 1'b0, "R10 oe on unknown opcode", misoOe, 0);
    csRelease();
    readStatus(st, oe);
    check(st == 8'h02, "R10 status after unknown opcode", st, 8'h02);

    // R2 latch set and clear, bit counts
    cmdByte(8'h04);
    readStatus(st, oe);
    check(st == 8'h00, "R2 clear latch", st, 8'h00);
    csAssert(); sendByte(8'h06); xferBits(8'h00, 1, rx, oe); csRelease();
    readStatus(st, oe);
    check(st == 8'h00, "R2 nine-bit set ignored", st, 8'h00);
    csAssert(); xferBits(8'h03, 7, rx, oe); csRelease();
    readStatus(st, oe);
    check(st == 8'h00, "R2 seven-bit set ignored", st, 8'h00);
    cmdByte(8'h06);
    readStatus(st, oe);
    check(st == 8'h02, "R2 set latch", st, 8'h02);

    // R4 write without latch
    cmdByte(8'h04);
    writeStatus(8'hFF);
    readStatus(st, oe);
    check(st == 8'h00, "R4 write without latch", st, 8'h00);

    // R6 R7 R8 sweep over data bytes
    prev = 8'h00;
    for (int i = 0; i < 64; i++) begin
      d = 8'((i * 37 + 11) & 255);
      cmdByte(8'h06);
      writeStatus(d);
      readStatus(st, oe);
      check(st == (prev | 8'h03), "R7 busy shows old bits", st, prev | 8'h03);
      waitIdle(st);
      check(st == (d & 8'h9C), "R6 R8 committed bits", st, d & 8'h9C);
      prev = d & 8'h9C;
    end
    cmdByte(8'h06);
    writeStatus(8'h00);
    waitIdle(st);
    prev = 8'h00;

    // R5 wrong bit counts discard
    cmdByte(8'h06);
    csAssert(); sendByte(8'h01); xferBits(8'h7F, 7, rx, oe); csRelease();
    readStatus(st, oe);
    check(st == 8'h02, "R5 fifteen bits discarded", st, 8'h02);
    csAssert(); sendByte(8'h01); sendByte(8'h9C); xferBits(8'h00, 1, rx, oe); csRelease();
    readStatus(st, oe);
    check(st == 8'h02, "R5 seventeen bits discarded", st, 8'h02);

    // R12 and R3 repeated read across end of busy
    writeStatus(8'h1C);
    writeStatus(8'h80);
    csAssert();
    sendByte(8'h05);
    for (int b = 0; b < 6; b++) begin
      xferBits(8'h00, 8, rx, oe);
      if (b == 0) check(rx == 8'h03, "R3 R12 first repeated byte busy", rx, 8'h03);
      if (b == 5) check(rx == 8'h1C, "R3 R8 last repeated byte done", rx, 8'h1C);
    end
    csRelease();
    readStatus(st, oe);
    check(st == 8'h1C, "R12 write during busy ignored", st, 8'h1C);

    // R9 lock bit with protect pin
    cmdByte(8'h06);
    writeStatus(8'h84);
    waitIdle(st);
    check(st == 8'h84, "R9 lock set", st, 8'h84);
    wpN = 1'b0;
    cmdByte(8'h06);
    writeStatus(8'h00);
    readStatus(st, oe);
    check(st == 8'h86, "R9 locked write rejected", st, 8'h86);
    wpN = 1'b1;
    tick(4);
    writeStatus(8'h10);
    waitIdle(st);
    check(st == 8'h10, "R9 write after pin released", st, 8'h10);

    // R11 device reset
    cmdByte(8'h06);
    devRstN = 1'b0;
    tick(20);
    csAssert();
    sendByte(8'h05);
    xferBits(8'h00, 8, rx, oe);
    check(oe == 1'b0, "R11 no output in reset", oe, 0);
    csRelease();
    cmdByte(8'h06);
    devRstN = 1'b1;
    tick(10);
    readStatus(st, oe);
    check(st == 8'h10, "R11 latch cleared, commands ignored", st, 8'h10);
    cmdByte(8'h06);
    writeStatus(8'h0C);
    devRstN = 1'b0;
    tick(WCYC + 50);
    devRstN = 1'b1;
    tick(10);
    readStatus(st, oe);
    check(st == 8'h0C, "R11 busy cycle completes", st, 8'h0C);

    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule